// File: doc/BRIEF.md
# Pulse Accumulator Counter

A 16-bit event and gated-time counter fed by one external input pin. In event mode the counter advances once per selected pin edge, falling or rising. In gated mode it advances once per divided bus-clock tick, but only while the pin sits at the selected level, high or low. The result is a measure of how long the gate was open.

Software reaches the block through a small byte-wide register port. A control byte holds the enable, the mode, the interrupt enables and a timer clock select. A flag byte holds an input-event flag and an overflow flag, and each flag is cleared by writing 1 to it. The count is read and preset as a high byte and a low byte.

The block also drives a single-cycle tick output to an external main timer. That tick is one of four sources: the external prescaler tick, every counter increment, every wrap of the low count byte, or every wrap of the full count. The main timer itself lies outside this block.

Top module: `pulse_acc_top`

Register map (`addr_i`): 0 = control, 1 = flags, 2 = count high byte, 3 = count low byte.

## Requirements
- R1: After reset, the control byte, the flag byte and both count bytes read 0x00, and `irq_edge_o` and `irq_ovf_o` are 0.
- R2: While control bit 6 (enable) is 0, pin activity changes neither the count nor the flags.
- R3: With enable set, control bits 5:4 = 00 count falling pin edges and 01 count rising pin edges, once per edge. The pin passes through a two-flop synchronizer first.
- R4: With enable set, control bits 5:4 = 10 add one count per GATE_DIV clock cycles while the synchronized pin is high, and 11 do the same while it is low. The divider restarts from zero whenever gated counting is not active.
- R5: Flag bit 0 (input event) sets on the counted edge in modes 00 and 01. In mode 10 it sets on the falling pin edge, and in mode 11 on the rising pin edge, which is the trailing edge of the gate.
- R6: An increment from 0xFFFF wraps the count to 0x0000 and sets flag bit 1 (overflow).
- R7: `irq_edge_o` equals flag bit 0 AND control bit 0, and `irq_ovf_o` equals flag bit 1 AND control bit 1.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R9: `tmr_tick_o` follows control bits 3:2. 00 selects `presc_tick_i`, 01 selects each counter increment, 10 selects an increment that wraps the low byte from 0xFF, and 11 selects an increment that wraps the count from 0xFFFF.
- R10: Writes to address 2 or 3 replace the high or low count byte, the write taking priority over a same-cycle increment, and reads return the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| presc_tick_i | input | 1 | Prescaler tick from the main timer |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_edge_o | output | 1 | Input-event interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt |
| tmr_tick_o | output | 1 | Selected clock enable for the main timer |

## Verification
The bench builds the block with GATE_DIV = 4 and SYNC_STAGES = 2. A divider of 4 makes a 40-cycle gate window an exact count of 10, and the divider phase is fixed by the control write. That makes both gated modes checkable to the exact count. Presetting the count bytes to 0x00FF and 0xFFFF puts the low-byte wrap, the full wrap and the overflow flag within a few pin edges.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    MODE_FALL    = 2'b00,
    MODE_RISE    = 2'b01,
    MODE_GATE_HI = 2'b10,
    MODE_GATE_LO = 2'b11
  } pa_mode_e;

  typedef enum logic [1:0] {
    TSEL_PRESC = 2'b00,
    TSEL_INC   = 2'b01,
    TSEL_LO    = 2'b10,
    TSEL_FULL  = 2'b11
  } pa_tsel_e;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_FLG  = 2'd1;
  localparam logic [1:0] ADDR_CNTH = 2'd2;
  localparam logic [1:0] ADDR_CNTL = 2'd3;

  localparam int CTL_EN  = 6;
  localparam int CTL_OIE = 1;
  localparam int CTL_EIE = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_EDG = 0;
endpackage

// File: rtl/pa_pin_sync.sv
module pa_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      lvl_d_q <= 1'b0;
    end else begin
      sr_q    <= {sr_q[STAGES-2:0], pin_i};
      lvl_d_q <= sr_q[STAGES-1];
    end
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = lvl_o & ~lvl_d_q;
  assign fall_o = ~lvl_o & lvl_d_q;

  // R3
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/pa_gate_div.sv
module pa_gate_div #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (!run_i || div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = run_i && (div_q == LAST);

  // R4
  div_tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIV > 1) && tick_o |=> !tick_o);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lo_wrap_o,
  output logic             full_wrap_o
);
  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cnt_q;
  logic             wr_any;

  assign wr_any = wr_hi_i | wr_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_hi_i) cnt_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
      if (wr_lo_i) cnt_q[7:0]       <= wdata_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o       = cnt_q;
  assign lo_wrap_o   = inc_i && !wr_any && (cnt_q[7:0] == 8'hFF);
  assign full_wrap_o = inc_i && !wr_any && (cnt_q == '1);

  // R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wrap_o |=> cnt_q == '0);
  // R10
  wr_lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> cnt_q[7:0] == $past(wdata_i));
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
  import pa_pkg::*;
#(
  parameter int GATE_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       presc_tick_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_edge_o,
  output logic       irq_ovf_o,
  output logic       tmr_tick_o
);
  localparam int CNT_W = 16;

  logic [6:0]       ctl_q;
  logic             flg_edg_q, flg_ovf_q;
  logic             en, gated;
  pa_mode_e         mode;
  pa_tsel_e         tsel;
  logic             lvl, rise, fall, tick;
  logic             inc, edge_evt;
  logic             wr_ctl, wr_flg, wr_hi, wr_lo;
  logic             clr_edg, clr_ovf;
  logic [CNT_W-1:0] cnt;
  logic             lo_wrap, full_wrap;

  assign wr_ctl = wr_en_i && addr_i == ADDR_CTL;
  assign wr_flg = wr_en_i && addr_i == ADDR_FLG;
  assign wr_hi  = wr_en_i && addr_i == ADDR_CNTH;
  assign wr_lo  = wr_en_i && addr_i == ADDR_CNTL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata_i[6:0];
  end

  assign en    = ctl_q[CTL_EN];
  assign mode  = pa_mode_e'(ctl_q[5:4]);
  assign tsel  = pa_tsel_e'(ctl_q[3:2]);
  assign gated = mode[1];

  pa_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  pa_gate_div #(.DIV(GATE_DIV)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en && gated),
    .tick_o (tick)
  );

  always_comb begin
    unique case (mode)
      MODE_FALL:    inc = fall;
      MODE_RISE:    inc = rise;
      MODE_GATE_HI: inc = tick & lvl;
      MODE_GATE_LO: inc = tick & ~lvl;
      default:      inc = 1'b0;
    endcase
    inc = inc & en;
    // trailing gate edge in gated modes
    edge_evt = en & ((mode == MODE_FALL || mode == MODE_GATE_HI) ? fall : rise);
  end

  pa_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (inc),
    .wr_hi_i     (wr_hi),
    .wr_lo_i     (wr_lo),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt),
    .lo_wrap_o   (lo_wrap),
    .full_wrap_o (full_wrap)
  );

  assign clr_edg = wr_flg && wdata_i[FLG_EDG];
  assign clr_ovf = wr_flg && wdata_i[FLG_OVF];

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_edg_q <= 1'b0;
      flg_ovf_q <= 1'b0;
    end else begin
      flg_edg_q <= edge_evt  | (flg_edg_q & ~clr_edg);
      flg_ovf_q <= full_wrap | (flg_ovf_q & ~clr_ovf);
    end
  end

  assign irq_edge_o = flg_edg_q & ctl_q[CTL_EIE];
  assign irq_ovf_o  = flg_ovf_q & ctl_q[CTL_OIE];

  always_comb begin
    unique case (tsel)
      TSEL_PRESC: tmr_tick_o = presc_tick_i;
      TSEL_INC:   tmr_tick_o = inc;
      TSEL_LO:    tmr_tick_o = lo_wrap;
      TSEL_FULL:  tmr_tick_o = full_wrap;
      default:    tmr_tick_o = 1'b0;
    endcase
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTL:  rdata_o = {1'b0, ctl_q};
      ADDR_FLG:  rdata_o = {6'b0, flg_ovf_q, flg_edg_q};
      ADDR_CNTH: rdata_o = cnt[15:8];
      ADDR_CNTL: rdata_o = cnt[7:0];
      default:   rdata_o = 8'h00;
    endcase
  end

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !wr_hi && !wr_lo |=> $stable(cnt));
  // R6
  ovf_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wrap |=> flg_ovf_q);
  // R8
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_evt && clr_edg |=> flg_edg_q);
  // R9
  wrap_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_wrap |-> lo_wrap && inc);
endmodule

// File: tb/pulse_acc_top_tb_top.sv
module pulse_acc_top_tb_top;
  typedef struct {
    int         kind;   // 0 rdata, 1 irq_edge, 2 irq_ovf, 3 tmr_tick
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       presc = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_edge, irq_ovf, tmr_tick;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  pulse_acc_top #(.GATE_DIV(4), .SYNC_STAGES(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_i        (pin),
    .presc_tick_i (presc),
    .wr_en_i      (wr_en),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .irq_edge_o   (irq_edge),
    .irq_ovf_o    (irq_ovf),
    .tmr_tick_o   (tmr_tick)
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0:       act = rdata;
          1:       act = {7'b0, irq_edge};
          2:       act = {7'b0, irq_ovf};
          default: act = {7'b0, tmr_tick};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    addr = a;
    push(0, exp, tag);
  endtask

  task automatic pulse();
    @(posedge clk); #1 pin = ~pin;
    repeat (4) @(posedge clk);
    #1 pin = ~pin;
    repeat (4) @(posedge clk);
  endtask

  // rising pin edge, check tmr_tick in the increment cycle
  task automatic rise_tick(logic exp, string tag);
    @(posedge clk); #1 pin = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    push(3, {7'b0, exp}, tag);
    @(posedge clk); #1;
    push(3, 8'h00, tag);
    repeat (3) @(posedge clk);
    #1 pin = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctl");
    rd(2'd1, 8'h00, "R1 flg");
    rd(2'd2, 8'h00, "R1 cnth");
    rd(2'd3, 8'h00, "R1 cntl");
    push(1, 8'h00, "R1 irq_edge");
    push(2, 8'h00, "R1 irq_ovf");

    // R2 disabled, rising mode selected
    wr(2'd0, 8'h10);
    pulse();
    rd(2'd3, 8'h00, "R2 count held");
    rd(2'd1, 8'h00, "R2 flags held");

    // R3 rising edges
    wr(2'd0, 8'h50);
    repeat (3) pulse();
    rd(2'd3, 8'h03, "R3 rising count");
    rd(2'd1, 8'h01, "R5 edge flag rising");

    // R3 falling edges
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h40);
    repeat (2) pulse();
    rd(2'd3, 8'h02, "R3 falling count");

    // R7 / R8
    wr(2'd0, 8'h41);
    push(1, 8'h01, "R7 irq_edge on");
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h01, "R8 write 0 keeps flag");
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h00, "R8 w1c clears");
    push(1, 8'h00, "R7 irq_edge off");

    // R8 set wins over same-cycle clear
    wr(2'd0, 8'h51);
    @(posedge clk); #1 pin = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(posedge clk); #1 wr_en = 1'b0;
    rd(2'd1, 8'h01, "R8 set priority");
    repeat (3) @(posedge clk);
    #1 pin = 1'b0;
    repeat (4) @(posedge clk);

    // R6 overflow, R10 byte access
    wr(2'd1, 8'h03);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, 8'hFF, "R10 cnth write");
    rd(2'd3, 8'hFF, "R10 cntl write");
    wr(2'd0, 8'h52);
    pulse();
    rd(2'd2, 8'h00, "R6 wrap hi");
    rd(2'd3, 8'h00, "R6 wrap lo");
    rd(2'd1, 8'h03, "R6 ovf flag");
    push(2, 8'h01, "R7 irq_ovf");

    // R9 timer tick select
    wr(2'd0, 8'h00);
    @(posedge clk); #1 presc = 1'b1;
    push(3, 8'h01, "R9 presc sel");
    @(posedge clk); #1 presc = 1'b0;
    push(3, 8'h00, "R9 presc low");
    wr(2'd0, 8'h54);
    rise_tick(1'b1, "R9 inc sel");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h58);
    rise_tick(1'b1, "R9 low wrap");
    rise_tick(1'b0, "R9 no low wrap");
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h5C);
    rise_tick(1'b1, "R9 full wrap");

    // R4 gated high: pin low gives nothing
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h60);
    repeat (40) @(posedge clk);
    rd(2'd3, 8'h00, "R4 gate high pin low");
    wr(2'd0, 8'h00);
    @(posedge clk); #1 pin = 1'b1;
    repeat (4) @(posedge clk);
    wr(2'd0, 8'h60);
    repeat (40) @(posedge clk);
    rd(2'd3, 8'h0A, "R4 gate high count");
    rd(2'd1, 8'h00, "R5 no flag on gate open");
    @(posedge clk); #1 pin = 1'b0;
    repeat (4) @(posedge clk);
    rd(2'd1, 8'h01, "R5 trailing edge gate high");

    // R4 gated low
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h70);
    repeat (40) @(posedge clk);
    rd(2'd3, 8'h0A, "R4 gate low count");
    @(posedge clk); #1 pin = 1'b1;
    repeat (4) @(posedge clk);
    rd(2'd1, 8'h01, "R5 trailing edge gate low");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule